// File: doc/BRIEF.md
# Three-Slot Instruction Fetch Queue

This block sits between an instruction fetch port and a decode stage. It holds up to three fetched instructions, each a 32-bit word with its 32-bit address. One of them sits in a decode slot and is presented downstream. Up to two more wait in prefetch slots behind it. Each cycle the queue may accept one fetched instruction through a ready/valid handshake. It releases the decode slot when the decode side takes it, and it moves the surviving entries forward so that the oldest one always occupies the decode slot.

Branch resolution drives two control inputs. The first, `dec_taken`, qualifies a release: it marks the instruction in decode as a taken branch. The next-oldest entry is then fetched down the wrong path, so it is thrown away instead of being promoted. The second, `flush`, empties the queue in one cycle.

An instruction that arrives at an empty queue lands directly in the decode slot. It is visible to decode on the next cycle and never waits in a prefetch slot.

Top module: `fetch_queue3`

## Requirements
- R1: After reset, `dec_valid` is 0 and `fetch_ready` is 1, and no instruction is presented until one has been accepted.
- R2: Accepted instructions reach decode in arrival order, each with its own address. None is duplicated, and none is lost unless R7 or R9 removes it.
- R3: When the queue is empty and a fetch is accepted without a flush, the next cycle shows `dec_valid` = 1 with that word and address.
- R4: At most two instructions wait behind decode. `fetch_ready` is 0 exactly when both prefetch slots are occupied and `dec_ready` is 0, and a fetch offered then is not taken.
- R5: While `dec_valid` = 1 and `dec_ready` = 0, and without a flush, the presented word and address stay unchanged on the next cycle.
- R6: A release happens in a cycle with `dec_valid` = 1 and `dec_ready` = 1. On a release, the decode slot is freed and the remaining entries move one position toward decode.
- R7: On a release with `dec_taken` = 1, the entry directly behind decode is discarded. The entry after it, if any, becomes the decode entry. A fetch accepted in the same cycle is kept and queued after the survivors.
- R8: On a release with `dec_taken` = 0, the entry directly behind decode is presented to decode on the next cycle.
- R9: `flush` = 1 empties all three slots on the next cycle, and a fetch offered in that cycle is dropped.
- R10: `dec_taken` has no effect in a cycle without a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue; a fetch in the same cycle is dropped |
| fetch_valid | input | 1 | Fetched instruction offered |
| fetch_ready | output | 1 | Queue can take the offered instruction |
| fetch_instr | input | 32 | Fetched instruction word |
| fetch_addr | input | 32 | Address of the fetched word |
| dec_valid | output | 1 | Decode slot holds an instruction |
| dec_ready | input | 1 | Decode side takes the presented instruction |
| dec_taken | input | 1 | Presented instruction is a taken branch (qualifies a release) |
| dec_instr | output | 32 | Instruction word in the decode slot |
| dec_addr | output | 32 | Address of the word in the decode slot |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edges have passed. They also assume that `dec_taken` matters only together with a release, and that the fetch side keeps word and address stable only while its offer is accepted, since the queue never looks back at an offer it refused. The stimulus starts in reset and drives every input at the falling clock edge. It mixes directed cycles for each corner with a long stretch of random valid, ready, taken and flush patterns. Each offered word carries a fresh sequence number, so a duplicated, reordered or misplaced entry changes the compared word.

// File: rtl/fq_pkg.sv
package fq_pkg;
  parameter int unsigned INSTR_W = 32;
  parameter int unsigned ADDR_W  = 32;

  typedef struct packed {
    logic [INSTR_W-1:0] instr;
    logic [ADDR_W-1:0]  addr;
  } fq_entry_t;
endpackage

// File: rtl/fq_slot.sv
module fq_slot
  import fq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      nxt_valid,
  input  fq_entry_t nxt_entry,
  output logic      valid_q,
  output fq_entry_t entry_q
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= nxt_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (nxt_valid) begin
      entry_q <= nxt_entry;
    end
  end

  // R9: a flush leaves this slot empty
  a_r9_slot_cleared: assert property (@(posedge clk) disable iff (rst)
    flush |=> !valid_q);
endmodule

// File: rtl/fq_ctrl.sv
module fq_ctrl #(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] valid_vec,
  input  logic             fetch_valid,
  input  logic             dec_ready,
  input  logic             dec_taken,
  input  logic             flush,
  output logic             fetch_ready,
  output logic             accept,
  output logic             release_o,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    pop_cnt
);
  always_comb begin
    count = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      count = count + CW'(valid_vec[i]);
    end
  end

  assign release_o   = valid_vec[0] & dec_ready;
  assign fetch_ready = !(valid_vec[DEPTH-1] && !dec_ready);
  assign accept      = fetch_valid & fetch_ready & ~flush;

  always_comb begin
    if (!release_o) begin
      pop_cnt = '0;
    end else if (dec_taken && count >= CW'(2)) begin
      pop_cnt = CW'(2);
    end else begin
      pop_cnt = CW'(1);
    end
  end

  // R2: occupied slots are packed toward decode
  genvar g;
  generate
    for (g = 1; g < DEPTH; g++) begin : g_pack
      a_r2_packed: assert property (@(posedge clk) disable iff (rst)
        valid_vec[g] |-> valid_vec[g-1]);
    end
  endgenerate

  // R4: a full queue never takes a fetch without freeing a slot
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (accept && valid_vec[DEPTH-1]) |-> release_o);
endmodule

// File: rtl/fetch_queue3.sv
module fetch_queue3
  import fq_pkg::*;
#(
  parameter int unsigned PF_SLOTS = 2,
  localparam int unsigned DEPTH = PF_SLOTS + 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               fetch_valid,
  output logic               fetch_ready,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic [ADDR_W-1:0]  fetch_addr,
  output logic               dec_valid,
  input  logic               dec_ready,
  input  logic               dec_taken,
  output logic [INSTR_W-1:0] dec_instr,
  output logic [ADDR_W-1:0]  dec_addr
);
  // slot 0 is the decode slot, higher indices are younger prefetch slots
  logic [DEPTH-1:0] v_q;
  fq_entry_t        ent_q [DEPTH];
  logic [DEPTH-1:0] v_nxt;
  fq_entry_t        ent_nxt [DEPTH];
  logic             accept;
  logic             rel;
  logic [CW-1:0]    count;
  logic [CW-1:0]    pop_cnt;
  fq_entry_t        in_ent;

  assign in_ent.instr = fetch_instr;
  assign in_ent.addr  = fetch_addr;

  fq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .valid_vec   (v_q),
    .fetch_valid (fetch_valid),
    .dec_ready   (dec_ready),
    .dec_taken   (dec_taken),
    .flush       (flush),
    .fetch_ready (fetch_ready),
    .accept      (accept),
    .release_o   (rel),
    .count       (count),
    .pop_cnt     (pop_cnt)
  );

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_slot
      always_comb begin
        v_nxt[k]   = 1'b0;
        ent_nxt[k] = in_ent;
        for (int j = 0; j < int'(DEPTH); j++) begin
          if (j == k + int'(pop_cnt) && j < int'(count)) begin
            v_nxt[k]   = 1'b1;
            ent_nxt[k] = ent_q[j];
          end
        end
        if (accept && k == int'(count) - int'(pop_cnt)) begin
          v_nxt[k]   = 1'b1;
          ent_nxt[k] = in_ent;
        end
      end

      fq_slot slot_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .nxt_valid (v_nxt[k]),
        .nxt_entry (ent_nxt[k]),
        .valid_q   (v_q[k]),
        .entry_q   (ent_q[k])
      );
    end
  endgenerate

  assign dec_valid = v_q[0];
  assign dec_instr = ent_q[0].instr;
  assign dec_addr  = ent_q[0].addr;

  // R3: an empty queue hands the arriving word straight to decode
  a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && accept) |=> dec_valid && dec_instr == $past(fetch_instr)
                                && dec_addr == $past(fetch_addr));

  // R5: a stalled decode slot holds its contents
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready && !flush) |=> dec_valid && $stable(dec_instr)
                                            && $stable(dec_addr));

  // R9: a flush leaves nothing presented
  a_r9_flush: assert property (@(posedge clk) disable iff (rst)
    flush |=> !dec_valid);

  generate
    if (PF_SLOTS >= 2) begin : g_branch_chk
      // R8: a not-taken release promotes the entry behind decode
      a_r8_promote: assert property (@(posedge clk) disable iff (rst)
        (rel && !dec_taken && v_q[1] && !flush)
          |=> dec_valid && dec_instr == $past(ent_q[1].instr));
      // R7: a taken release skips the entry behind decode
      a_r7_skip: assert property (@(posedge clk) disable iff (rst)
        (rel && dec_taken && v_q[2] && !flush)
          |=> dec_valid && dec_instr == $past(ent_q[2].instr));
    end
  endgenerate
endmodule

// File: tb/fetch_queue3_tb_top.sv
`timescale 1ns/1ps
module fetch_queue3_tb_top;
  localparam int DEPTH = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_instr = '0;
  logic [31:0] fetch_addr = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic        dec_taken = 1'b0;
  logic [31:0] dec_instr;
  logic [31:0] dec_addr;

  int n_checks = 0;
  int n_fail = 0;
  int seq = 0;
  logic [63:0] mq[$];

  always #2.5 clk = ~clk;

  fetch_queue3 dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_instr(fetch_instr), .fetch_addr(fetch_addr),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_taken(dec_taken),
    .dec_instr(dec_instr), .dec_addr(dec_addr)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_dec(string req);
    chk(req, "dec_valid", 64'(dec_valid), 64'(mq.size() > 0));
    if (mq.size() > 0 && dec_valid) begin
      chk(req, "dec_word", {dec_instr, dec_addr}, mq[0]);
    end
  endtask

  // one cycle: drive at the falling edge, check, advance the model
  task automatic step(string req, bit fv, bit dr, bit tk, bit fl);
    bit exp_rdy;
    logic [63:0] w;
    w = {32'hA000_0000 + 32'(seq), 32'(seq) * 32'd4};
    fetch_valid = fv; dec_ready = dr; dec_taken = tk; flush = fl;
    fetch_instr = w[63:32]; fetch_addr = w[31:0];
    #1;
    exp_rdy = !(mq.size() == DEPTH && !dr);
    chk(req, "fetch_ready", 64'(fetch_ready), 64'(exp_rdy));
    if (fl) begin
      mq.delete();
    end else begin
      if (mq.size() > 0 && dr) begin
        void'(mq.pop_front());
        if (tk && mq.size() > 0) void'(mq.pop_front());
      end
      if (fv && exp_rdy) mq.push_back(w);
    end
    if (fv) seq++;
    @(negedge clk);
    chk_dec(req);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "dec_valid", 64'(dec_valid), 64'd0);
    chk("R1", "fetch_ready", 64'(fetch_ready), 64'd1);
    step("R1", 0, 1, 0, 0);
    step("R3", 1, 0, 0, 0);          // bypass into decode
    step("R4", 1, 0, 0, 0);
    step("R4", 1, 0, 0, 0);          // now full
    step("R4", 1, 0, 0, 0);          // refused
    step("R5", 0, 0, 0, 0);
    step("R10", 0, 0, 1, 0);         // taken without release
    step("R8", 0, 1, 0, 0);          // promote
    step("R4", 1, 0, 0, 0);          // refill
    step("R7", 1, 1, 1, 0);          // taken, fetch kept
    step("R7", 0, 1, 1, 0);
    step("R6", 0, 1, 0, 0);
    step("R6", 0, 1, 0, 0);
    step("R10", 0, 1, 1, 0);         // taken with empty queue
    step("R3", 1, 1, 0, 0);
    step("R9", 1, 0, 0, 0);
    step("R9", 1, 0, 0, 1);          // flush drops fetch
    step("R9", 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      step("R2", ($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 40) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule